// File: doc/BRIEF.md
# Packed SIMD Media ALU

This block is a lane-partitioned arithmetic unit for a media datapath. It treats each 64-bit operand as a row of independent lanes: eight bytes, four halfwords or two words. A lane-size field picks the split. One opcode applies one operation to every lane at once. The operations are add and subtract (wrapping, signed-clamping or unsigned-clamping), shifts by a common amount, bitwise logic, a 16-bit multiply and a pairwise multiply-accumulate, compares that produce lane masks, and a narrowing pack that clamps values too wide for the smaller element.

The unit has one register stage. Operands, opcode, lane size and shift amount are sampled on a rising clock edge while `in_valid` is high. The 64-bit result and `out_valid` appear after that edge. When `in_valid` is low, the result register keeps its last value. A compare result can be used directly as a select mask by later bitwise operations.

Top module: `simd_media_alu`

## Requirements
- R1: A vector sampled with `in_valid` high gives its result and `out_valid`=1 after the same rising edge. After an edge with `in_valid` low, `out_valid` is 0 and `result` is unchanged.
- R2: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R3: Opcodes 0 (add) and 3 (subtract, A minus B) wrap modulo the lane width. Lane size 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Lane i occupies bits [i*w +: w].
- R4: Opcodes 1 (add) and 4 (subtract) treat lanes as two's complement. On overflow they clamp to the most positive or most negative lane value.
- R5: Opcodes 2 (add) and 5 (subtract) treat lanes as unsigned. They clamp to all ones on carry and to zero on borrow.
- R6: Opcodes 6 (left), 7 (logical right) and 8 (arithmetic right) shift each lane of A by `shamt`. An amount of at least the lane width gives zero for 6 and 7, and the lane's sign bit in every position for 8.
- R7: Opcodes 9 (A AND B), 10 (A AND NOT B), 11 (OR) and 12 (XOR) act on all 64 bits and do not depend on the lane size.
- R8: Opcode 13 multiplies the four 16-bit lanes and keeps the low 16 bits of each product. The lane size is ignored.
- R9: Opcode 14 forms four signed 16x16 products. Products of lanes 0 and 1 are summed into word 0, and products of lanes 2 and 3 into word 1, wrapping at 32 bits. The lane size is ignored.
- R10: Opcode 15 (equal) and opcode 16 (signed A greater than B) set each lane to all ones when true and to all zeros when false.
- R11: Opcode 17 narrows signed elements with clamping. With lane size 1, halfwords become bytes; with lane size 2, words become halfwords. A's elements fill the low half of the result in lane order, and B's fill the high half. Any other lane size gives zero.
- R12: Opcodes 18 to 31 give zero. Opcodes 0–8, 15 and 16 with lane size 3 also give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are sampled this edge |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 5 | Operation select, codes as in the requirements |
| lane_size | input | 2 | 0: bytes, 1: halfwords, 2: words, 3: reserved |
| shamt | input | 6 | Shift amount shared by all lanes |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |

## Verification
Every result is due one rising edge after the vector is sampled: a single register stands between the inputs and `result`. The bench changes inputs on the falling edge and reads the output on the next falling edge, half a cycle after the register loads and before the next vector is sampled. It drives vectors back to back, so each check sees the output of exactly one vector. For the hold rule it drops `in_valid`, changes the operands, and reads the output on the following falling edge. There it expects the previous result and a low `out_valid`.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int SIMD_DW = 64;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDS  = 5'd1,
    OP_ADDU  = 5'd2,
    OP_SUB   = 5'd3,
    OP_SUBS  = 5'd4,
    OP_SUBU  = 5'd5,
    OP_SLL   = 5'd6,
    OP_SRL   = 5'd7,
    OP_SRA   = 5'd8,
    OP_AND   = 5'd9,
    OP_ANDN  = 5'd10,
    OP_OR    = 5'd11,
    OP_XOR   = 5'd12,
    OP_MULLO = 5'd13,
    OP_MADD  = 5'd14,
    OP_CEQ   = 5'd15,
    OP_CGT   = 5'd16,
    OP_PACK  = 5'd17
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_RSV = 2'd3
  } simd_sz_e;

  // signed clamp of a halfword into a byte
  function automatic logic [7:0] narrow_h2b(logic [15:0] v);
    if (!v[15] && (v[14:7] != 8'h00)) return 8'h7F;
    if (v[15] && (v[14:7] != 8'hFF))  return 8'h80;
    return v[7:0];
  endfunction

  // signed clamp of a word into a halfword
  function automatic logic [15:0] narrow_w2h(logic [31:0] v);
    if (!v[31] && (v[30:15] != 16'h0000)) return 16'h7FFF;
    if (v[31] && (v[30:15] != 16'hFFFF))  return 16'h8000;
    return v[15:0];
  endfunction

  // every lane is uniformly ones or zeros
  function automatic logic lanes_uniform(logic [SIMD_DW-1:0] v, logic [1:0] sz);
    int w;
    logic ok;
    w  = 8 << sz;
    ok = 1'b1;
    for (int i = 0; i < SIMD_DW; i++)
      if (v[i] != v[(i / w) * w]) ok = 1'b0;
    return ok;
  endfunction

  // every unsigned lane of hi is not below the same lane of lo
  function automatic logic lanes_not_below(logic [SIMD_DW-1:0] hi, logic [SIMD_DW-1:0] lo,
                                           logic [1:0] sz);
    int w;
    logic [SIMD_DW-1:0] m;
    logic ok;
    w  = 8 << sz;
    m  = ({{(SIMD_DW-1){1'b0}}, 1'b1} << w) - 1'b1;
    ok = 1'b1;
    for (int l = 0; l < SIMD_DW; l += 8)
      if ((l % w) == 0)
        if (((hi >> l) & m) < ((lo >> l) & m)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit import simd_pkg::*; #(
  parameter int DW  = 64,
  parameter int LW  = 8,
  parameter int SHW = 6
) (
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [4:0]     op,
  input  logic [SHW-1:0] shamt,
  output logic [DW-1:0]  res
);
  localparam int NL = DW / LW;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic shift_out;
  assign shift_out = (int'(shamt) >= LW);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] x, y, r;
    logic [LW:0]   sum, dif;
    logic          ovf_add, ovf_sub;

    assign x   = a[g*LW +: LW];
    assign y   = b[g*LW +: LW];
    assign sum = {1'b0, x} + {1'b0, y};
    assign dif = {1'b0, x} - {1'b0, y};
    assign ovf_add = (x[LW-1] == y[LW-1]) && (sum[LW-1] != x[LW-1]);
    assign ovf_sub = (x[LW-1] != y[LW-1]) && (dif[LW-1] != x[LW-1]);

    always_comb begin
      r = '0;
      case (op)
        OP_ADD:  r = sum[LW-1:0];
        OP_ADDS: r = ovf_add ? (x[LW-1] ? SMIN : SMAX) : sum[LW-1:0];
        OP_ADDU: r = sum[LW] ? '1 : sum[LW-1:0];
        OP_SUB:  r = dif[LW-1:0];
        OP_SUBS: r = ovf_sub ? (x[LW-1] ? SMIN : SMAX) : dif[LW-1:0];
        OP_SUBU: r = dif[LW] ? '0 : dif[LW-1:0];
        OP_SLL:  r = shift_out ? '0 : (x << shamt);
        OP_SRL:  r = shift_out ? '0 : (x >> shamt);
        OP_SRA:  r = shift_out ? {LW{x[LW-1]}} : LW'($signed(x) >>> shamt);
        OP_CEQ:  r = {LW{x == y}};
        OP_CGT:  r = {LW{$signed(x) > $signed(y)}};
        default: r = '0;
      endcase
    end

    assign res[g*LW +: LW] = r;
  end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] mul_lo,
  output logic [DW-1:0] madd
);
  localparam int HW = 16;
  localparam int NH = DW / HW;
  localparam int NP = NH / 2;

  logic [2*HW-1:0] prod [NH];

  for (genvar g = 0; g < NH; g++) begin : g_prod
    logic [2*HW-1:0] xa, yb;
    assign xa = {{HW{a[g*HW+HW-1]}}, a[g*HW +: HW]};
    assign yb = {{HW{b[g*HW+HW-1]}}, b[g*HW +: HW]};
    assign prod[g] = xa * yb;
    assign mul_lo[g*HW +: HW] = prod[g][HW-1:0];
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign madd[p*2*HW +: 2*HW] = prod[2*p] + prod[2*p+1];
  end
endmodule

// File: rtl/simd_pack.sv
module simd_pack import simd_pkg::*; #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sz,
  output logic [DW-1:0] res
);
  localparam int HALF = DW / 2;
  localparam int NH   = DW / 16;
  localparam int NW   = DW / 32;

  logic [DW-1:0] res_h2b, res_w2h;

  for (genvar g = 0; g < NH; g++) begin : g_h2b
    assign res_h2b[g*8 +: 8]        = narrow_h2b(a[g*16 +: 16]);
    assign res_h2b[HALF+g*8 +: 8]   = narrow_h2b(b[g*16 +: 16]);
  end

  for (genvar g = 0; g < NW; g++) begin : g_w2h
    assign res_w2h[g*16 +: 16]      = narrow_w2h(a[g*32 +: 32]);
    assign res_w2h[HALF+g*16 +: 16] = narrow_w2h(b[g*32 +: 32]);
  end

  always_comb begin
    case (sz)
      SZ_H:    res = res_h2b;
      SZ_W:    res = res_w2h;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu import simd_pkg::*; #(
  parameter int DW  = SIMD_DW,
  parameter int OPW = 5,
  parameter int SZW = 2,
  parameter int SHW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic [OPW-1:0] opcode,
  input  logic [SZW-1:0] lane_size,
  input  logic [SHW-1:0] shamt,
  output logic           out_valid,
  output logic [DW-1:0]  result
);
  localparam int NUM_SIZES = 3;

  logic [DW-1:0] lane_res [NUM_SIZES];
  logic [DW-1:0] mul_lo, madd, pack_res, next_res;

  // named events for the checks below
  logic is_lane_op, size_ok, bad_op, is_cmp;
  assign is_lane_op = (opcode <= OP_SRA) || (opcode == OP_CEQ) || (opcode == OP_CGT);
  assign is_cmp     = (opcode == OP_CEQ) || (opcode == OP_CGT);
  assign size_ok    = (lane_size != SZ_RSV);
  assign bad_op     = (opcode > OP_PACK);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
    simd_lane_unit #(.DW(DW), .LW(8 << k), .SHW(SHW)) u_lane (
      .a(op_a), .b(op_b), .op(opcode), .shamt(shamt), .res(lane_res[k])
    );
  end

  simd_mul16 #(.DW(DW)) u_mul (.a(op_a), .b(op_b), .mul_lo(mul_lo), .madd(madd));
  simd_pack  #(.DW(DW)) u_pack (.a(op_a), .b(op_b), .sz(lane_size), .res(pack_res));

  always_comb begin
    next_res = '0;
    case (opcode)
      OP_AND:   next_res = op_a & op_b;
      OP_ANDN:  next_res = op_a & ~op_b;
      OP_OR:    next_res = op_a | op_b;
      OP_XOR:   next_res = op_a ^ op_b;
      OP_MULLO: next_res = mul_lo;
      OP_MADD:  next_res = madd;
      OP_PACK:  next_res = pack_res;
      default: begin
        if (is_lane_op) begin
          case (lane_size)
            SZ_B:    next_res = lane_res[0];
            SZ_H:    next_res = lane_res[1];
            SZ_W:    next_res = lane_res[2];
            default: next_res = '0;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_usat_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADDU && size_ok) |=>
      (lanes_not_below(result, $past(op_a), $past(lane_size)) &&
       lanes_not_below(result, $past(op_b), $past(lane_size))));

  assert_usat_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_SUBU && size_ok) |=>
      lanes_not_below($past(op_a), result, $past(lane_size)));

  assert_cmp_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp && size_ok) |=> lanes_uniform(result, $past(lane_size)));

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (bad_op || (is_lane_op && !size_ok))) |=> (result == '0));
endmodule

// File: tb/sim_simd_media_alu.sv
module sim_simd_media_alu;
  localparam int C_ADD = 0, C_ADDS = 1, C_ADDU = 2, C_SUB = 3, C_SUBS = 4, C_SUBU = 5,
                 C_SLL = 6, C_SRL = 7, C_SRA = 8, C_AND = 9, C_ANDN = 10, C_OR = 11,
                 C_XOR = 12, C_MUL = 13, C_MADD = 14, C_CEQ = 15, C_CGT = 16, C_PACK = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [4:0]  opcode = '0;
  logic [1:0]  lane_size = '0;
  logic [5:0]  shamt = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  logic [63:0] last_exp = '0;

  always #5 clk = ~clk;

  simd_media_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane_size(lane_size), .shamt(shamt),
    .out_valid(out_valid), .result(result)
  );

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint sext(longint u, int w);
    return (u >= (longint'(1) << (w - 1))) ? u - (longint'(1) << w) : u;
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, int op, int sz, int sh);
    logic [63:0] r, lm;
    int w;
    longint ua, ub, sa, sb, v, p0, p1;
    r = '0;
    case (op)
      C_AND:  return a & b;
      C_ANDN: return a & ~b;
      C_OR:   return a | b;
      C_XOR:  return a ^ b;
      C_MUL: begin
        for (int i = 0; i < 4; i++) begin
          p0 = sext(longint'((a >> (16*i)) & 64'hFFFF), 16) * sext(longint'((b >> (16*i)) & 64'hFFFF), 16);
          r |= (64'(p0) & 64'hFFFF) << (16*i);
        end
        return r;
      end
      C_MADD: begin
        for (int j = 0; j < 2; j++) begin
          p0 = sext(longint'((a >> (32*j)) & 64'hFFFF), 16) * sext(longint'((b >> (32*j)) & 64'hFFFF), 16);
          p1 = sext(longint'((a >> (32*j+16)) & 64'hFFFF), 16) * sext(longint'((b >> (32*j+16)) & 64'hFFFF), 16);
          r |= (64'(p0 + p1) & 64'hFFFF_FFFF) << (32*j);
        end
        return r;
      end
      C_PACK: begin
        if (sz == 1) begin
          for (int i = 0; i < 4; i++) begin
            v = clampv(sext(longint'((a >> (16*i)) & 64'hFFFF), 16), -128, 127);
            r |= (64'(v) & 64'hFF) << (8*i);
            v = clampv(sext(longint'((b >> (16*i)) & 64'hFFFF), 16), -128, 127);
            r |= (64'(v) & 64'hFF) << (32 + 8*i);
          end
        end else if (sz == 2) begin
          for (int i = 0; i < 2; i++) begin
            v = clampv(sext(longint'((a >> (32*i)) & 64'hFFFF_FFFF), 32), -32768, 32767);
            r |= (64'(v) & 64'hFFFF) << (16*i);
            v = clampv(sext(longint'((b >> (32*i)) & 64'hFFFF_FFFF), 32), -32768, 32767);
            r |= (64'(v) & 64'hFFFF) << (32 + 16*i);
          end
        end
        return r;
      end
      default: ;
    endcase
    if (op > C_PACK || sz == 3) return '0;
    w  = 8 << sz;
    lm = (64'd1 << w) - 64'd1;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'((a >> (i*w)) & lm);
      ub = longint'((b >> (i*w)) & lm);
      sa = sext(ua, w);
      sb = sext(ub, w);
      case (op)
        C_ADD:  v = ua + ub;
        C_ADDS: v = clampv(sa + sb, -(longint'(1) << (w-1)), (longint'(1) << (w-1)) - 1);
        C_ADDU: v = clampv(ua + ub, 0, (longint'(1) << w) - 1);
        C_SUB:  v = ua - ub;
        C_SUBS: v = clampv(sa - sb, -(longint'(1) << (w-1)), (longint'(1) << (w-1)) - 1);
        C_SUBU: v = clampv(ua - ub, 0, (longint'(1) << w) - 1);
        C_SLL:  v = (sh >= w) ? 0 : (ua << sh);
        C_SRL:  v = (sh >= w) ? 0 : (ua >> sh);
        C_SRA:  v = (sh >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> sh);
        C_CEQ:  v = (ua == ub) ? -1 : 0;
        C_CGT:  v = (sa > sb) ? -1 : 0;
        default: v = 0;
      endcase
      r |= (64'(v) & lm) << (i*w);
    end
    return r;
  endfunction

  function automatic string tag_of(int op, int sz);
    if (op > C_PACK) return "R12";
    if ((op <= C_SRA || op == C_CEQ || op == C_CGT) && sz == 3) return "R12";
    case (op)
      C_ADD, C_SUB: return "R3";
      C_ADDS, C_SUBS: return "R4";
      C_ADDU, C_SUBU: return "R5";
      C_SLL, C_SRL, C_SRA: return "R6";
      C_AND, C_ANDN, C_OR, C_XOR: return "R7";
      C_MUL: return "R8";
      C_MADD: return "R9";
      C_CEQ, C_CGT: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_vec(input logic [63:0] a, input logic [63:0] b, input int op, input int sz,
                         input int sh, input string req);
    logic [63:0] e;
    e = model(a, b, op, sz, sh);
    op_a = a; op_b = b; opcode = 5'(op); lane_size = 2'(sz); shamt = 6'(sh);
    in_valid = 1'b1;
    @(negedge clk);
    check(req, {out_valid, result}, {1'b1, e});
    last_exp = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R2", {out_valid, result}, 65'd0);
    rst_n = 1'b1;

    // directed corners
    run_vec(64'hFF7F_00FF_0180_FFFF, 64'h0101_0001_0180_0101, C_ADD, 0, 0, "R3");
    run_vec(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, C_SUB, 1, 0, "R3");
    run_vec(64'h7F80_7F80_0000_0000, 64'h01FF_7F80_0000_0000, C_ADDS, 0, 0, "R4");
    run_vec(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, C_SUBS, 2, 0, "R4");
    run_vec(64'hFFFF_FF00_0001_0002, 64'h0001_0101_0001_0003, C_ADDU, 1, 0, "R5");
    run_vec(64'h0000_0010_0505_0A0A, 64'h0001_0001_0606_0909, C_SUBU, 0, 0, "R5");
    run_vec(64'h8123_4567_89AB_CDEF, 64'h0, C_SLL, 0, 8, "R6");
    run_vec(64'h8123_4567_09AB_CDEF, 64'h0, C_SRA, 2, 40, "R6");
    run_vec(64'h8123_4567_89AB_CDEF, 64'h0, C_SRL, 1, 15, "R6");
    run_vec(64'hF0F0_F0F0_FFFF_0000, 64'hFF00_FF00_0F0F_FFFF, C_ANDN, 3, 0, "R7");
    run_vec(64'h8000_8000_FFFF_0003, 64'h8000_7FFF_FFFF_0005, C_MUL, 2, 0, "R8");
    run_vec(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, C_MADD, 0, 0, "R9");
    run_vec(64'h0102_0304_8001_0000, 64'h0102_0305_0180_0000, C_CGT, 0, 0, "R10");
    run_vec(64'h1234_1234_0000_FFFF, 64'h1234_1235_0000_FFFF, C_CEQ, 1, 0, "R10");
    run_vec(64'h7FFF_0100_FF80_8000, 64'h0055_FF7F_0000_FFFF, C_PACK, 1, 0, "R11");
    run_vec(64'h0001_0000_FFFF_7FFF, 64'hFFFF_8000_0000_1234, C_PACK, 2, 0, "R11");
    run_vec(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, C_PACK, 0, 0, "R11");
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, C_ADD, 3, 0, "R12");
    run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 31, 0, 0, "R12");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a, b;
      int op, sz, sh;
      a  = {$urandom, $urandom};
      b  = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 4) == 0) a = a | 64'h8080_8080_8080_8080;
      op = ($urandom_range(0, 15) == 0) ? int'($urandom_range(18, 31)) : int'($urandom_range(0, 17));
      sz = ($urandom_range(0, 9) == 0) ? 3 : int'($urandom_range(0, 2));
      sh = int'($urandom_range(0, 63));
      run_vec(a, b, op, sz, sh, tag_of(op, sz));
    end

    // hold with in_valid low
    in_valid = 1'b0;
    op_a = ~op_a; op_b = ~op_b; opcode = 5'(C_XOR);
    @(negedge clk);
    check("R1", {out_valid, result}, {1'b0, last_exp});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule